// File: doc/BRIEF.md
# One-bit sigma-delta DAC modulator

This block turns a stream of 32-bit audio-rate samples into a single oversampled output bit whose running average follows the sample value. The bit is meant to drive an external analog low-pass filter. A digital noise shaper produces the bit. It runs as a second-order loop by default, and a configuration input can drop it to first order. The shaper pushes quantisation noise up towards high frequencies, where the analog filter removes it.

Samples arrive on a ready/valid port. The block raises ready for one clock cycle in every oversampling period. The length of that period, in output bits per input sample, is programmable from 32 to 256. The output bit rate is therefore the input sample rate times that factor: an 8 kHz input at a factor of 256 gives a 2048 kHz bit stream. A format input selects whether samples are signed two's complement or offset binary. When no sample is offered at the moment ready is high, the shaper keeps using the last accepted sample.

Top module: `bitstream_dac`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `dac_bit` is 0, `s_ready` is 1, and both integrators hold zero.
- R2: `s_ready` is high for exactly one cycle in every period of N cycles. N is `cfg_osr` clamped into the range 32..256, so a value below 32 behaves as 32 and a value above 256 behaves as 256.
- R3: A sample is taken only on a clock edge where `s_valid` and `s_ready` are both high. It drives the first integrator from the next edge onwards. Data present on other cycles has no effect.
- R4: If `s_valid` is low while `s_ready` is high, the previously accepted sample keeps driving the shaper for the whole next period.
- R5: With `cfg_offset_bin` at 0 the sample is read as two's complement. With `cfg_offset_bin` at 1 it is read as offset binary: bit 31 is inverted to obtain the signed value, so 0x8000_0000 means zero.
- R6: With `cfg_order2` at 1, every clock updates the state as follows: a ← sat(a + x − f), b ← sat(b + a_old − f), where f is +2^31 when the current `dac_bit` is 1 and −2^31 when it is 0.
- R7: With `cfg_order2` at 0, the update is a ← sat(a + x − f), and the second integrator is forced to zero.
- R8: The integrators are 36 bits wide. sat() clamps to the range [−2^35, 2^35−1], so no input sequence can make an integrator wrap around.
- R9: The next `dac_bit` is 1 exactly when the new value of the last active integrator is zero or positive. That integrator is b in second order and a in first order.
- R10: For a constant input of +2^30 (half of positive full scale), the fraction of ones in the output lies between 0.70 and 0.80 over 2048 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one output bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| cfg_order2 | input | 1 | 1 = second-order shaper, 0 = first-order |
| cfg_offset_bin | input | 1 | 1 = samples are offset binary, 0 = two's complement |
| cfg_osr | input | 9 | Oversampling factor, clamped to 32..256 |
| s_valid | input | 1 | Sample offered |
| s_data | input | 32 | Sample value |
| s_ready | output | 1 | Block takes a sample on this cycle |
| dac_bit | output | 1 | Oversampled one-bit output |

## Verification
A behavioural model follows the integrator and ready sequence. It is compared against the design on every cycle, and the design is driven with several input patterns:
- Constant inputs at zero, half scale and both full-scale extremes. Between them these show the sign decision, the feedback polarity and the saturation clamp.
- A rapidly changing data bus with valid held high. Only the values present at ready edges should matter, so this separates correct acceptance from sampling on every cycle.
- Offset-binary and first-order runs of the same values. These show that the format and order options change only what they should.
- Long runs with valid low, and oversampling settings outside the legal range. The ready gap is measured directly in these runs.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

   typedef enum logic {
      FMT_TWOS   = 1'b0,
      FMT_OFFSET = 1'b1
   } sample_fmt_e;

   typedef enum logic {
      ORDER_ONE = 1'b0,
      ORDER_TWO = 1'b1
   } shaper_order_e;

endpackage

// File: rtl/bsd_rate_gen.sv
module bsd_rate_gen #(
   parameter int OSR_MIN = 32,
   parameter int OSR_MAX = 256,
   parameter int OSR_W   = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [OSR_W-1:0] osr_i,
   output logic             tick_o
);

   localparam logic [OSR_W-1:0] LIM_LO = OSR_W'(OSR_MIN);
   localparam logic [OSR_W-1:0] LIM_HI = OSR_W'(OSR_MAX);

   logic [OSR_W-1:0] osr_eff;
   logic [OSR_W-1:0] cnt_q;

   always_comb begin
      if (osr_i < LIM_LO)      osr_eff = LIM_LO;
      else if (osr_i > LIM_HI) osr_eff = LIM_HI;
      else                     osr_eff = osr_i;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (cnt_q >= osr_eff - OSR_W'(1)) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + OSR_W'(1);
      end
   end

   assign tick_o = (cnt_q == '0);

   // R2: a request never lasts two cycles in a row (period is at least OSR_MIN)
   assert_ready_single_R2 : assert property (@(posedge clk) disable iff (rst)
      tick_o |=> !tick_o);

endmodule

// File: rtl/bsd_sample_hold.sv
module bsd_sample_hold
   import bsd_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic                 clk,
   input  logic                 rst,
   input  sample_fmt_e          fmt_i,
   input  logic                 take_i,
   input  logic [DW-1:0]        data_i,
   output logic signed [DW-1:0] x_o
);

   logic [DW-1:0] signed_form;
   logic [DW-1:0] x_q;

   always_comb begin
      signed_form = data_i;
      if (fmt_i == FMT_OFFSET) begin
         signed_form[DW-1] = ~data_i[DW-1];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         x_q <= '0;
      end else if (take_i) begin
         x_q <= signed_form;
      end
   end

   assign x_o = $signed(x_q);

   // R4: without a transfer the held sample stays put
   assert_hold_R4 : assert property (@(posedge clk) disable iff (rst)
      !take_i |=> $stable(x_q));

endmodule

// File: rtl/bsd_shaper.sv
module bsd_shaper
   import bsd_pkg::*;
#(
   parameter int DW         = 32,
   parameter int GUARD      = 4,
   parameter bit HAS_ORDER2 = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  shaper_order_e        order_i,
   input  logic signed [DW-1:0] x_i,
   output logic                 bit_o
);

   localparam int IW = DW + GUARD;
   localparam int SW = IW + 2;
   localparam logic signed [SW-1:0] FB_POS = SW'(1) <<< (DW - 1);
   localparam logic signed [SW-1:0] FB_NEG = -FB_POS;
   localparam logic signed [SW-1:0] SAT_HI = (SW'(1) <<< (IW - 1)) - SW'(1);
   localparam logic signed [SW-1:0] SAT_LO = -(SW'(1) <<< (IW - 1));

   function automatic logic signed [IW-1:0] clip(input logic signed [SW-1:0] v);
      if (v > SAT_HI)      return SAT_HI[IW-1:0];
      else if (v < SAT_LO) return SAT_LO[IW-1:0];
      else                 return v[IW-1:0];
   endfunction

   logic signed [IW-1:0] i1_q, i1_n;
   logic signed [SW-1:0] x_w, fb_w, i1_w, s1;
   logic                 dac_q, dac_n;

   assign x_w  = SW'(x_i);
   assign i1_w = SW'(i1_q);
   assign fb_w = dac_q ? FB_POS : FB_NEG;
   assign s1   = i1_w + x_w - fb_w;
   assign i1_n = clip(s1);

   always_ff @(posedge clk) begin
      if (rst) begin
         i1_q  <= '0;
         dac_q <= 1'b0;
      end else begin
         i1_q  <= i1_n;
         dac_q <= dac_n;
      end
   end

   generate
      if (HAS_ORDER2) begin : g_two
         logic signed [IW-1:0] i2_q, i2_n;
         logic signed [SW-1:0] s2;

         assign s2   = SW'(i2_q) + i1_w - fb_w;
         assign i2_n = (order_i == ORDER_TWO) ? clip(s2) : '0;
         assign dac_n = (order_i == ORDER_TWO) ? ~i2_n[IW-1] : ~i1_n[IW-1];

         always_ff @(posedge clk) begin
            if (rst) i2_q <= '0;
            else     i2_q <= i2_n;
         end

         // R7: first-order operation leaves the second stage empty
         assert_order1_clear_R7 : assert property (@(posedge clk) disable iff (rst)
            (order_i == ORDER_ONE) |=> (i2_q == '0));
      end else begin : g_one
         assign dac_n = ~i1_n[IW-1];
      end
   endgenerate

   assign bit_o = dac_q;

   // R8: non-negative state plus non-negative input and negative feedback cannot turn negative
   assert_no_wrap_R8 : assert property (@(posedge clk) disable iff (rst)
      (!i1_q[IW-1] && !x_i[DW-1] && !dac_q) |=> !i1_q[IW-1]);

   // R8: a negative state with negative input and positive feedback stays negative
   assert_no_wrap_neg_R8 : assert property (@(posedge clk) disable iff (rst)
      (i1_q[IW-1] && x_i[DW-1] && dac_q) |=> i1_q[IW-1]);

endmodule

// File: rtl/bitstream_dac.sv
module bitstream_dac
   import bsd_pkg::*;
#(
   parameter int DW         = 32,
   parameter int GUARD      = 4,
   parameter int OSR_MIN    = 32,
   parameter int OSR_MAX    = 256,
   parameter bit HAS_ORDER2 = 1'b1,
   localparam int OSR_W     = $clog2(OSR_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_order2,
   input  logic             cfg_offset_bin,
   input  logic [OSR_W-1:0] cfg_osr,
   input  logic             s_valid,
   input  logic [DW-1:0]    s_data,
   output logic             s_ready,
   output logic             dac_bit
);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("bitstream_dac: DW must be at least 8");
      end
      if (GUARD < 2) begin : g_bad_guard
         $error("bitstream_dac: GUARD needs at least 2 bits");
      end
      if (OSR_MIN < 2 || OSR_MAX < OSR_MIN) begin : g_bad_osr
         $error("bitstream_dac: oversampling range is invalid");
      end
   endgenerate

   sample_fmt_e          fmt;
   shaper_order_e        order;
   logic                 take;
   logic signed [DW-1:0] x_cur;

   assign fmt   = cfg_offset_bin ? FMT_OFFSET : FMT_TWOS;
   assign order = cfg_order2 ? ORDER_TWO : ORDER_ONE;
   assign take  = s_valid && s_ready;

   bsd_rate_gen #(
      .OSR_MIN (OSR_MIN),
      .OSR_MAX (OSR_MAX),
      .OSR_W   (OSR_W)
   ) u_rate (
      .clk    (clk),
      .rst    (rst),
      .osr_i  (cfg_osr),
      .tick_o (s_ready)
   );

   bsd_sample_hold #(
      .DW (DW)
   ) u_hold (
      .clk    (clk),
      .rst    (rst),
      .fmt_i  (fmt),
      .take_i (take),
      .data_i (s_data),
      .x_o    (x_cur)
   );

   bsd_shaper #(
      .DW         (DW),
      .GUARD      (GUARD),
      .HAS_ORDER2 (HAS_ORDER2)
   ) u_shape (
      .clk     (clk),
      .rst     (rst),
      .order_i (order),
      .x_i     (x_cur),
      .bit_o   (dac_bit)
   );

   // R1: first cycle out of reset shows the cleared state
   assert_reset_state_R1 : assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!dac_bit && s_ready));

endmodule

// File: tb/sim_bitstream_dac.sv
module sim_bitstream_dac;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_order2 = 1'b1;
   logic        cfg_offset_bin = 1'b0;
   logic [8:0]  cfg_osr = 9'd32;
   logic        s_valid = 1'b0;
   logic [31:0] s_data = '0;
   logic        s_ready, dac_bit;

   always #5 clk = ~clk;

   bitstream_dac u0 (
      .clk(clk), .rst(rst), .cfg_order2(cfg_order2), .cfg_offset_bin(cfg_offset_bin),
      .cfg_osr(cfg_osr), .s_valid(s_valid), .s_data(s_data),
      .s_ready(s_ready), .dac_bit(dac_bit)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   bit    cmp_on = 1'b0;
   bit    done = 1'b0;
   string cur_req = "R6";

   localparam longint FS   = 64'sd1 <<< 31;
   localparam longint SHI  = (64'sd1 <<< 35) - 1;
   localparam longint SLO  = -(64'sd1 <<< 35);

   longint m_i1 = 0, m_i2 = 0, m_xh = 0;
   int     m_cnt = 0;
   bit     m_q = 1'b0;

   function automatic longint sat(longint v);
      if (v > SHI) return SHI;
      if (v < SLO) return SLO;
      return v;
   endfunction

   function automatic longint to_signed(logic [31:0] d, bit offs);
      logic [31:0] t;
      t = offs ? (d ^ 32'h8000_0000) : d;
      return longint'($signed(t));
   endfunction

   function automatic int clamp_osr(int v);
      if (v < 32)  return 32;
      if (v > 256) return 256;
      return v;
   endfunction

   // behavioural reference, advanced on each rising edge
   always @(posedge clk) begin
      if (rst) begin
         m_i1 = 0; m_i2 = 0; m_xh = 0; m_q = 1'b0; m_cnt = 0;
      end else begin
         longint f, n1, n2;
         bit     rdy;
         int     lim;
         f   = m_q ? FS : -FS;
         n1  = sat(m_i1 + m_xh - f);
         if (cfg_order2) begin
            n2 = sat(m_i2 + m_i1 - f);
            m_q = (n2 >= 0);
         end else begin
            n2 = 0;
            m_q = (n1 >= 0);
         end
         m_i1 = n1; m_i2 = n2;
         rdy = (m_cnt == 0);
         if (s_valid && rdy) m_xh = to_signed(s_data, cfg_offset_bin);
         lim = clamp_osr(int'(cfg_osr));
         if (m_cnt >= lim - 1) m_cnt = 0;
         else                  m_cnt = m_cnt + 1;
      end
   end

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         chk(dac_bit == m_q, cur_req, dac_bit, m_q);
         chk(s_ready == (m_cnt == 0), "R2", s_ready, (m_cnt == 0));
      end
   end

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ramp(int n, logic [31:0] step);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         s_data = s_data + step;
      end
   endtask

   task automatic gap_check(int exp);
      int n;
      while (!s_ready) @(negedge clk);
      do @(negedge clk); while (!s_ready);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!s_ready);
      chk(n == exp, "R2", n, exp);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int ones;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: released state before any active edge
      chk(dac_bit == 1'b0, "R1", dac_bit, 0);
      chk(s_ready == 1'b1, "R1", s_ready, 1);
      cmp_on = 1'b1;

      // R1: idle zero input right after reset follows cleared integrators
      cur_req = "R1";
      cycles(64);

      // R6 / R9: second order, two's complement, constant levels
      cur_req = "R6";
      s_valid = 1'b1;
      s_data = 32'h0000_0000;        cycles(200);
      s_data = 32'h4000_0000;        cycles(300);
      cur_req = "R9";
      s_data = 32'hC000_0000;        cycles(300);
      // R8: full-scale extremes drive the saturation limits
      cur_req = "R8";
      s_data = 32'h7FFF_FFFF;        cycles(600);
      s_data = 32'h8000_0000;        cycles(600);

      // R3: data changing every cycle, only ready-edge values count
      cur_req = "R3";
      ramp(800, 32'h1357_9BDF);

      // R4: valid low, garbage on the bus is ignored
      cur_req = "R4";
      s_data = 32'h2000_0000; cycles(40);
      s_valid = 1'b0;
      ramp(300, 32'h7654_3211);
      s_valid = 1'b1;

      // R5: offset binary, 0x8000_0000 is zero, 0xC000_0000 is +half
      cur_req = "R5";
      cfg_offset_bin = 1'b1;
      s_data = 32'h8000_0000; cycles(300);
      s_data = 32'hC000_0000; cycles(300);
      s_data = 32'h0000_0000; cycles(300);
      cfg_offset_bin = 1'b0;

      // R7: first order
      cur_req = "R7";
      cfg_order2 = 1'b0;
      s_data = 32'h3000_0000; cycles(300);
      s_data = 32'hE000_0000; cycles(300);
      ramp(300, 32'h0F0F_0F0F);
      cfg_order2 = 1'b1;
      cur_req = "R6";
      s_data = 32'h1000_0000; cycles(300);

      // R2: period lengths, including clamped settings
      cfg_osr = 9'd256; gap_check(256);
      cfg_osr = 9'd100; gap_check(100);
      cfg_osr = 9'd10;  gap_check(32);
      cfg_osr = 9'd400; gap_check(256);
      cfg_osr = 9'd32;  gap_check(32);

      // R10: density of ones at +half scale
      cur_req = "R10";
      s_data = 32'h4000_0000;
      cycles(200);
      ones = 0;
      for (int k = 0; k < 2048; k++) begin
         @(negedge clk);
         if (dac_bit) ones++;
      end
      chk(ones >= 1434 && ones <= 1638, "R10", ones, 1536);

      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule